// File: doc/BRIEF.md
# Eight-Channel PWM Bank with Shared Time Base

This block drives eight pulse-width-modulated outputs from a single up-counter. A programmable prescaler divides the clock by an even factor and advances the counter by one step per tick. A shared wrap register sets the highest count, so a smaller wrap value gives a shorter period and a higher output frequency at lower resolution. Each channel compares the counter against its own duty value. Two per-channel masks then choose the polarity and whether the channel drives at all.

Software programs the block through a small write/read register bus. Duty values can be written at any time. Each write goes to a staging register and reaches the comparator only when the counter returns to zero, so a period is never cut short or stretched by a mid-period update.

Top module: `pwm_bank`

## Requirements
- R1: After reset, the duty registers (addresses 0 to 7) read 00h, the wrap register (address 8) reads FFh, the count (address 9) reads 00h, the control register (address 10) reads 0Ch, the invert mask (address 11) reads 00h, the enable mask (address 12) reads 00h, and `pwm_o` is 00h.
- R2: A write to address 0–7, 8, 10, 11 or 12 is returned by a read of that address. Addresses 13 to 15 read 00h. Writes to address 9 and to addresses 13 to 15 change nothing.
- R3: Control bits [6:0] hold a divide code P, and the counter advances once every 2*(P+1) clocks. While control bit 7 is 1, the counter and the prescaler hold still, and the prescaler restarts from zero when the bit clears.
- R4: On each tick the counter steps by one. A tick taken while the counter is equal to or above the wrap value returns the counter to 0, including when the wrap value has been lowered below the current count.
- R5: For an enabled, non-inverted channel, `pwm_o[i]` is 1 exactly while count < active duty of channel i. Duty 00h therefore gives a constant 0, and a duty above the wrap value gives a constant 1. The output follows the count in the same cycle.
- R6: Bit i of the invert mask set to 1 inverts `pwm_o[i]` of an enabled channel.
- R7: Bit i of the enable mask at 0 forces `pwm_o[i]` to 0, whatever the invert bit is.
- R8: A new duty value reads back at once, but the comparator uses it only from the tick on which the counter returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pwm_o | output | 8 | PWM outputs, one bit per channel |

## Verification
The duty set spans 0, 1, mid values, exactly the wrap value, one above it, and far above it. This separates a strict less-than compare from an off-by-one compare and exposes the two constant-output cases. Invert and enable masks in alternating bit patterns show whether polarity and gating are applied per bit and in the correct order. The bench writes duty values mid-period and lowers the wrap value below the running count, which tells staged loading apart from immediate loading and tests the greater-or-equal wrap condition. It also stops the counter and switches between divide codes, to confirm the tick spacing and the restart from zero.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned ADDR_W     = 4;
    localparam logic [ADDR_W-1:0] A_WRAP  = 4'd8;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd9;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd10;
    localparam logic [ADDR_W-1:0] A_INV   = 4'd11;
    localparam logic [ADDR_W-1:0] A_EN    = 4'd12;
    localparam logic [7:0] CTRL_RESET = 8'h0C;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CH = 8,
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DW-1:0]          wdata,
    output logic [CH-1:0][DW-1:0]  duty,
    output logic [DW-1:0]          wrap,
    output logic [DW-1:0]          ctrl,
    output logic [CH-1:0]          inv,
    output logic [CH-1:0]          en
);
    localparam int CIW = (CH > 1) ? $clog2(CH) : 1;

    typedef struct packed {
        logic [CH-1:0][DW-1:0] duty;
        logic [DW-1:0]         wrap;
        logic [DW-1:0]         ctrl;
        logic [CH-1:0]         inv;
        logic [CH-1:0]         en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (int'(addr) < CH) begin
                r_d.duty[addr[CIW-1:0]] = wdata;
            end else begin
                case (addr)
                    A_WRAP:  r_d.wrap = wdata;
                    A_CTRL:  r_d.ctrl = wdata;
                    A_INV:   r_d.inv  = wdata[CH-1:0];
                    A_EN:    r_d.en   = wdata[CH-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.duty <= '0;
            r_q.wrap <= '1;
            r_q.ctrl <= DW'(CTRL_RESET);
            r_q.inv  <= '0;
            r_q.en   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign duty = r_q.duty;
    assign wrap = r_q.wrap;
    assign ctrl = r_q.ctrl;
    assign inv  = r_q.inv;
    assign en   = r_q.en;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ctrl,
    input  logic [DW-1:0] wrap,
    output logic [DW-1:0] cnt,
    output logic          wrap_evt
);
    typedef struct packed {
        logic [DW-1:0] pre;
        logic [DW-1:0] cnt;
    } tb_t;

    tb_t t_d, t_q;
    logic          halt;
    logic          tick;
    logic [DW-1:0] limit;

    assign halt  = ctrl[DW-1];
    assign limit = {ctrl[DW-2:0], 1'b1};
    assign tick  = !halt && (t_q.pre >= limit);
    assign wrap_evt = tick && (t_q.cnt >= wrap);

    always_comb begin
        t_d = t_q;
        if (halt || tick) t_d.pre = '0;
        else              t_d.pre = t_q.pre + 1'b1;
        if (tick) begin
            if (t_q.cnt >= wrap) t_d.cnt = '0;
            else                 t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cnt = t_q.cnt;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap_evt,
    input  logic [DW-1:0] duty_stage,
    input  logic [DW-1:0] cnt,
    input  logic          inv,
    input  logic          en,
    output logic [DW-1:0] duty_act,
    output logic          pwm
);
    logic [DW-1:0] act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (wrap_evt) act_d = duty_stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign duty_act = act_q;
    assign pwm      = en & ((cnt < act_q) ^ inv);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int CH = 8,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [CH-1:0]     pwm_o
);
    localparam int CIW = (CH > 1) ? $clog2(CH) : 1;

    logic [CH-1:0][DW-1:0] duty;
    logic [CH-1:0][DW-1:0] act_all;
    logic [DW-1:0]         wrap;
    logic [DW-1:0]         ctrl;
    logic [CH-1:0]         inv;
    logic [CH-1:0]         en_mask;
    logic [DW-1:0]         cnt;
    logic                  wrap_evt;

    pwm_regs #(.CH(CH), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .duty(duty), .wrap(wrap), .ctrl(ctrl), .inv(inv), .en(en_mask)
    );

    pwm_timebase #(.DW(DW)) u_tb (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .wrap(wrap),
        .cnt(cnt), .wrap_evt(wrap_evt)
    );

    for (genvar i = 0; i < CH; i++) begin : g_ch
        pwm_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt),
            .duty_stage(duty[i]), .cnt(cnt), .inv(inv[i]), .en(en_mask[i]),
            .duty_act(act_all[i]), .pwm(pwm_o[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) < CH) begin
            rdata = duty[addr[CIW-1:0]];
        end else begin
            case (addr)
                A_WRAP:  rdata = wrap;
                A_COUNT: rdata = cnt;
                A_CTRL:  rdata = ctrl;
                A_INV:   rdata = DW'(inv);
                A_EN:    rdata = DW'(en_mask);
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int CH = 8,
    parameter int DW = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [DW-1:0]         cnt,
    input logic                  halt,
    input logic [CH-1:0][DW-1:0] act,
    input logic [CH-1:0]         en,
    input logic [CH-1:0]         pwm_o
);
    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(cnt));

    // R8
    act_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> (cnt == '0));

    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o & ~en) == '0);
endmodule

bind pwm_bank pwm_bank_chk #(.CH(CH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .halt(ctrl[DW-1]),
    .act(act_all), .en(en_mask), .pwm_o(pwm_o)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pwm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    pwm_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o));

    always #2.5 clk = ~clk;

    // behavioural reference
    int m_duty[8];
    int m_act[8];
    int m_wrap, m_ctrl, m_inv, m_en, m_pre, m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_duty[i] = 0; m_act[i] = 0; end
            m_wrap = 255; m_ctrl = 12; m_inv = 0; m_en = 0; m_pre = 0; m_cnt = 0;
        end else begin
            int  lim;
            bit  stop, tk;
            lim  = 2 * (m_ctrl % 128) + 1;
            stop = (m_ctrl >= 128);
            tk   = !stop && (m_pre >= lim);
            if (stop || tk) m_pre = 0; else m_pre = m_pre + 1;
            if (tk) begin
                if (m_cnt >= m_wrap) begin
                    m_cnt = 0;
                    for (int i = 0; i < 8; i++) m_act[i] = m_duty[i];
                end else m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                if (addr < 8) m_duty[addr] = wdata;
                else if (addr == 8)  m_wrap = wdata;
                else if (addr == 10) m_ctrl = wdata;
                else if (addr == 11) m_inv  = wdata;
                else if (addr == 12) m_en   = wdata;
            end
        end
    end

    function automatic logic [7:0] model_pwm();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            bit raw;
            raw = (m_cnt < m_act[i]);
            v[i] = ((m_en >> i) & 1) ? (raw ^ bit'((m_inv >> i) & 1)) : 1'b0;
        end
        return v;
    endfunction

    // per-cycle output comparison: R5 R6 R7 R8
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (pwm_o !== model_pwm()) begin
                n_bad++;
                $display("FAIL R5 R6 R7 R8 pwm_o cnt=%0d got %02h exp %02h",
                         m_cnt, pwm_o, model_pwm());
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        addr = 4'(a);
        #0.5;
        n_chk++;
        if (rdata !== 8'(exp)) begin
            n_bad++;
            $display("FAIL %s addr %0d got %02h exp %02h", tag, a, rdata, 8'(exp));
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        for (int a = 0; a < 8; a++) rd(a, 0, "R1");
        rd(8, 8'hFF, "R1"); rd(9, 0, "R1"); rd(10, 8'h0C, "R1");
        rd(11, 0, "R1"); rd(12, 0, "R1");
        n_chk++;
        if (pwm_o !== 8'h00) begin n_bad++; $display("FAIL R1 pwm_o got %02h exp 00", pwm_o); end

        // R3 default divide 26: after 60 clocks two ticks have occurred
        idle(55);
        rd(9, m_cnt, "R3");

        // R2 readback of all writable registers
        wr(8, 15); wr(10, 0);
        wr(0, 0); wr(1, 1); wr(2, 5); wr(3, 8); wr(4, 15); wr(5, 16); wr(6, 200); wr(7, 3);
        rd(0, 0, "R2"); rd(2, 5, "R2"); rd(6, 200, "R2"); rd(8, 15, "R2"); rd(10, 0, "R2");
        wr(12, 8'hFF);
        rd(12, 8'hFF, "R2");
        idle(150);               // R5 duty 0 low, duty 16 > wrap high
        rd(9, m_cnt, "R4");

        // R6 inversion
        wr(11, 8'h5A);
        rd(11, 8'h5A, "R6");
        idle(100);

        // R7 gating
        wr(12, 8'h0F);
        idle(100);
        wr(12, 8'h00);
        idle(20);
        n_chk++;
        if (pwm_o !== 8'h00) begin n_bad++; $display("FAIL R7 pwm_o got %02h exp 00", pwm_o); end
        wr(12, 8'hFF); wr(11, 0);

        // R8 mid-period duty update
        while (m_cnt != 4) @(negedge clk);
        wr(0, 12); wr(7, 0);
        rd(0, 12, "R8"); rd(7, 0, "R8");
        idle(80);

        // R4 wrap lowered below running count
        while (m_cnt <= 9) @(negedge clk);
        wr(8, 3);
        rd(9, m_cnt, "R4");
        idle(20);
        rd(9, m_cnt, "R4");
        wr(8, 15);

        // R3 halt and slower divide
        wr(10, 8'h80);
        rd(9, m_cnt, "R3");
        c0 = m_cnt;
        idle(20);
        rd(9, c0, "R3");
        wr(10, 2);
        idle(13);
        rd(9, m_cnt, "R3");
        idle(100);

        // R2 ignored writes
        c0 = m_cnt;
        wr(9, 8'h77);
        rd(9, m_cnt, "R2");
        wr(13, 8'h55);
        rd(13, 0, "R2"); rd(14, 0, "R2"); rd(15, 0, "R2");
        rd(8, 15, "R2"); rd(10, 2, "R2");

        // R5 full resolution
        wr(10, 0); wr(8, 8'hFF); wr(0, 128); wr(1, 255);
        idle(1200);
        rd(9, m_cnt, "R4");

        finish_run();
    end
endmodule